// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address, or into a fault code. It takes one request per cycle and answers one cycle later. Each request is routed down one of four paths, in priority order. An odd fetch address is a privileged-code PC and skips translation. Physical mode passes the address through unchanged. A superpage window maps kernel fetches straight onto the physical space. Every other request is mapped through a page-table entry.

The translation array lives outside the block. For mapped requests the unit drives a lookup strobe, the virtual page number and the address-space identifier. In the same cycle the array answers with hit, page frame number and per-mode execute enables.

After the path result is formed, the unit runs two more steps. It rejects addresses that have bits set above the implemented physical width. It marks addresses with the uncacheable bit set and strips a control field from them. On a miss or an access violation it keeps the faulting PC and a formatted page-table-entry address, and holds them until the next such fault.

Top module: `ift_xlate_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `rsp_vld`, `rsp_pa`, `rsp_fault`, `rsp_uncached`, `flt_va` and `flt_form` all become zero.
- R2: A request sampled with `req_vld` high produces `rsp_vld` high on the following cycle. A cycle with `req_vld` low produces `rsp_vld` low on the following cycle.
- R3: A request with `req_va[0]`=1 has the highest priority. Its result is `req_va` with bits 1:0 cleared and bits 63:44 cleared, with fault code 0. It never asserts `tlb_req`.
- R4: A request with `req_va[0]`=0 and `req_phys`=1 uses `req_va` unchanged as the physical address.
- R5: A request that takes neither of the paths above is a superpage access when `sp_ctl[1]`=1 and `req_va[42:41]`=2'b10, or when `req_va[47:41]`=7'h7E. Any other request asserts `tlb_req`, with `tlb_vpn`=`req_va[42:13]` and `tlb_asid`=`cur_asid`.
- R6: A superpage access with `cur_mode` not 0 (0 = kernel) returns fault code 1 (access violation).
- R7: A kernel superpage access takes `req_va[43:0]`. If bit 40 of that value is 1, bits 43:40 are forced to 1. Otherwise only bits 39:0 are kept.
- R8: A mapped request with `tlb_hit`=0 returns fault code 2 (fetch miss).
- R9: A mapped hit forms `(tlb_ppn << 13) + {req_va[12:2], 2'b00}`. If `tlb_xre[cur_mode]`=0, it returns fault code 1 instead.
- R10: On fault code 1 or 2, `flt_va` takes `req_va` and `flt_form` takes `pt_base | (req_va[42:13] << 3)`. Both hold their values on every other cycle.
- R11: If the computed address of a fault-free path has any bit at or above bit 44 set, the result is fault code 3 (machine check). Whenever the fault code is not 0, `rsp_pa` is 0 and `rsp_uncached` is 0.
- R12: A fault-free result with bit 39 set raises `rsp_uncached`, and has bits 42:35 cleared in `rsp_pa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Fetch request valid |
| req_va | input | 64 | Fetch virtual address |
| req_phys | input | 1 | Physical-mode flag |
| cur_mode | input | 2 | Current privilege mode, 0 = kernel |
| sp_ctl | input | 2 | Superpage control, bit 1 enables the narrow window |
| cur_asid | input | 8 | Current address-space identifier |
| pt_base | input | 64 | Page-table base for formatted fault address |
| tlb_req | output | 1 | Lookup strobe to external translation array |
| tlb_vpn | output | 30 | Virtual page number for lookup |
| tlb_asid | output | 8 | Address-space identifier for lookup |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 32 | Page frame number of hit entry |
| tlb_xre | input | 4 | Execute enable per mode of hit entry |
| rsp_vld | output | 1 | Result valid |
| rsp_pa | output | 44 | Physical address |
| rsp_fault | output | 3 | Fault code: 0 none, 1 access violation, 2 miss, 3 machine check |
| rsp_uncached | output | 1 | Uncacheable access |
| flt_va | output | 64 | Last faulting PC |
| flt_form | output | 64 | Last formatted page-table-entry address |

## Verification
The hardest case to reach is where three steps act on the same address. A superpage address with both bit 40 and bit 39 set is first sign-extended into bits 43:40 and then stripped of bits 42:35. Only bit 43 of the extension survives. Random addresses almost never land in that window with those bits set, so the stimulus builds the window pattern on purpose for both superpage forms and sets bits 40 and 39 directly. It does the same for page frame numbers that push the sum past bit 43, and for narrow-window addresses sent with the superpage control cleared, which must fall through to a lookup.

// File: rtl/ift_pkg.sv
package ift_pkg;
    parameter int VA_W       = 64;
    parameter int PA_W       = 44;
    parameter int PAGE_SHIFT = 13;
    parameter int VPN_W      = 30;
    parameter int PPN_W      = 32;
    parameter int ASID_W     = 8;
    parameter int MODE_W     = 2;
    parameter int SP_CTL_W   = 2;

    localparam int NMODES       = 1 << MODE_W;
    localparam int SP_NARROW_LO = 41;
    localparam int SP_WIDE_HI   = 47;
    localparam int SEXT_BIT     = 40;
    localparam int UNC_BIT      = 39;
    localparam int UNC_CLR_HI   = 42;
    localparam int UNC_CLR_LO   = 35;
    localparam int FORM_SHIFT   = 3;

    typedef logic [VA_W-1:0] addr_t;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_ACV  = 3'd1,
        FLT_MISS = 3'd2,
        FLT_MCHK = 3'd3
    } fault_e;

    typedef enum logic [1:0] {
        PATH_PRIV,
        PATH_PHYS,
        PATH_SPAGE,
        PATH_MAPPED
    } path_e;

    localparam logic [MODE_W-1:0] MODE_KERNEL = '0;

    typedef struct packed {
        addr_t  addr;
        fault_e flt;
        logic   rec;
    } xlate_t;

    function automatic addr_t bit_range(input int hi, input int lo);
        addr_t m;
        for (int i = 0; i < VA_W; i++) begin
            m[i] = (i >= lo) && (i <= hi);
        end
        return m;
    endfunction

    function automatic addr_t impl_mask(input addr_t a);
        return a & bit_range(PA_W-1, 0);
    endfunction

    function automatic logic spage_match(input addr_t va, input logic [SP_CTL_W-1:0] ctl);
        logic narrow;
        logic wide;
        narrow = ctl[1] && (va[SP_NARROW_LO+1:SP_NARROW_LO] == 2'b10);
        wide   = (va[SP_WIDE_HI:SP_NARROW_LO] == 7'h7E);
        return narrow || wide;
    endfunction

    function automatic addr_t spage_map(input addr_t va);
        addr_t a;
        a = impl_mask(va);
        if (a[SEXT_BIT]) begin
            a = a | bit_range(PA_W-1, SEXT_BIT);
        end else begin
            a = a & bit_range(SEXT_BIT-1, 0);
        end
        return a;
    endfunction

    function automatic logic [VPN_W-1:0] vpn_of(input addr_t va);
        return va[PAGE_SHIFT+VPN_W-1:PAGE_SHIFT];
    endfunction
endpackage

// File: rtl/ift_route.sv
module ift_route
    import ift_pkg::*;
(
    input  addr_t                va,
    input  logic                 phys,
    input  logic [SP_CTL_W-1:0]  sp_ctl,
    output path_e                path
);
    always_comb begin
        if (va[0]) begin
            path = PATH_PRIV;
        end else if (phys) begin
            path = PATH_PHYS;
        end else if (spage_match(va, sp_ctl)) begin
            path = PATH_SPAGE;
        end else begin
            path = PATH_MAPPED;
        end
    end
endmodule

// File: rtl/ift_direct.sv
module ift_direct
    import ift_pkg::*;
(
    input  addr_t               va,
    input  path_e               path,
    input  logic [MODE_W-1:0]   mode,
    output xlate_t              res
);
    always_comb begin
        res.addr = '0;
        res.flt  = FLT_NONE;
        res.rec  = 1'b0;
        unique case (path)
            PATH_PRIV: begin
                res.addr = impl_mask(va & ~bit_range(1, 0));
            end
            PATH_PHYS: begin
                res.addr = va;
            end
            PATH_SPAGE: begin
                if (mode != MODE_KERNEL) begin
                    res.flt = FLT_ACV;
                    res.rec = 1'b1;
                end else begin
                    res.addr = spage_map(va);
                end
            end
            default: begin
                res.addr = '0;
            end
        endcase
    end
endmodule

// File: rtl/ift_mapped.sv
module ift_mapped
    import ift_pkg::*;
(
    input  logic [PAGE_SHIFT-1:2] ofs_hi,
    input  logic [MODE_W-1:0]     mode,
    input  logic                  hit,
    input  logic [PPN_W-1:0]      ppn,
    input  logic [NMODES-1:0]     xre,
    output xlate_t                res
);
    localparam int PAD_W = VA_W - PPN_W - PAGE_SHIFT;
    localparam int OFS_PAD_W = VA_W - PAGE_SHIFT;

    addr_t frame;
    addr_t offset;

    assign frame  = {{PAD_W{1'b0}}, ppn, {PAGE_SHIFT{1'b0}}};
    assign offset = {{OFS_PAD_W{1'b0}}, ofs_hi, 2'b00};

    always_comb begin
        res.addr = '0;
        res.flt  = FLT_NONE;
        res.rec  = 1'b0;
        if (!hit) begin
            res.flt = FLT_MISS;
            res.rec = 1'b1;
        end else begin
            res.addr = frame + offset;
            if (!xre[mode]) begin
                res.flt = FLT_ACV;
                res.rec = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ift_finish.sv
module ift_finish
    import ift_pkg::*;
(
    input  addr_t             raw_addr,
    input  fault_e            raw_flt,
    output logic [PA_W-1:0]   pa,
    output fault_e            flt,
    output logic              unc
);
    addr_t cleaned;

    always_comb begin
        pa      = '0;
        unc     = 1'b0;
        flt     = raw_flt;
        cleaned = raw_addr;
        if (raw_flt == FLT_NONE) begin
            if (|raw_addr[VA_W-1:PA_W]) begin
                flt = FLT_MCHK;
            end else begin
                unc = raw_addr[UNC_BIT];
                if (unc) begin
                    cleaned = raw_addr & ~bit_range(UNC_CLR_HI, UNC_CLR_LO);
                end
                pa = cleaned[PA_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ift_xlate_unit.sv
module ift_xlate_unit
    import ift_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_vld,
    input  logic [VA_W-1:0]       req_va,
    input  logic                  req_phys,
    input  logic [MODE_W-1:0]     cur_mode,
    input  logic [SP_CTL_W-1:0]   sp_ctl,
    input  logic [ASID_W-1:0]     cur_asid,
    input  logic [VA_W-1:0]       pt_base,
    output logic                  tlb_req,
    output logic [VPN_W-1:0]      tlb_vpn,
    output logic [ASID_W-1:0]     tlb_asid,
    input  logic                  tlb_hit,
    input  logic [PPN_W-1:0]      tlb_ppn,
    input  logic [NMODES-1:0]     tlb_xre,
    output logic                  rsp_vld,
    output logic [PA_W-1:0]       rsp_pa,
    output logic [2:0]            rsp_fault,
    output logic                  rsp_uncached,
    output logic [VA_W-1:0]       flt_va,
    output logic [VA_W-1:0]       flt_form
);
    localparam int FORM_PAD_W = VA_W - VPN_W - FORM_SHIFT;

    path_e            path;
    xlate_t           direct_res;
    xlate_t           mapped_res;
    xlate_t           sel_res;
    logic [PA_W-1:0]  fin_pa;
    fault_e           fin_flt;
    logic             fin_unc;
    addr_t            form_addr;

    ift_route u_route (
        .va     (req_va),
        .phys   (req_phys),
        .sp_ctl (sp_ctl),
        .path   (path)
    );

    ift_direct u_direct (
        .va   (req_va),
        .path (path),
        .mode (cur_mode),
        .res  (direct_res)
    );

    ift_mapped u_mapped (
        .ofs_hi (req_va[PAGE_SHIFT-1:2]),
        .mode   (cur_mode),
        .hit    (tlb_hit),
        .ppn    (tlb_ppn),
        .xre    (tlb_xre),
        .res    (mapped_res)
    );

    assign sel_res = (path == PATH_MAPPED) ? mapped_res : direct_res;

    ift_finish u_finish (
        .raw_addr (sel_res.addr),
        .raw_flt  (sel_res.flt),
        .pa       (fin_pa),
        .flt      (fin_flt),
        .unc      (fin_unc)
    );

    assign tlb_req   = req_vld && (path == PATH_MAPPED);
    assign tlb_vpn   = vpn_of(req_va);
    assign tlb_asid  = cur_asid;
    assign form_addr = pt_base | {{FORM_PAD_W{1'b0}}, vpn_of(req_va), {FORM_SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld      <= 1'b0;
            rsp_pa       <= '0;
            rsp_fault    <= FLT_NONE;
            rsp_uncached <= 1'b0;
            flt_va       <= '0;
            flt_form     <= '0;
        end else begin
            rsp_vld <= req_vld;
            if (req_vld) begin
                rsp_pa       <= fin_pa;
                rsp_fault    <= fin_flt;
                rsp_uncached <= fin_unc;
                if (sel_res.rec) begin
                    flt_va   <= req_va;
                    flt_form <= form_addr;
                end
            end
        end
    end

    AST_VLD_NEXT: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> rsp_vld); // R2
    AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> !rsp_vld); // R2
    AST_PRIV_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_va[0]) |=> (rsp_fault == FLT_NONE && rsp_pa[1:0] == 2'b00)); // R3
    AST_PRIV_NO_LOOKUP: assert property (@(posedge clk) disable iff (rst)
        req_va[0] |-> !tlb_req); // R3
    AST_PHYS_NO_XLATE_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_vld && req_phys && !req_va[0]) |=> (rsp_fault != FLT_MISS && rsp_fault != FLT_ACV)); // R4
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_uncached)); // R11
    AST_UNC_FIELD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rsp_vld && rsp_uncached) |-> (rsp_pa[UNC_CLR_HI:UNC_CLR_LO] == '0)); // R12
    AST_FLT_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> ($stable(flt_va) && $stable(flt_form))); // R10
endmodule

// File: tb/ift_xlate_unit_bench.sv
`timescale 1ns/1ps
module ift_xlate_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_vld = 1'b0;
    logic [63:0] req_va = '0;
    logic        req_phys = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [1:0]  sp_ctl = '0;
    logic [7:0]  cur_asid = '0;
    logic [63:0] pt_base = 64'h0000_0200_0000_0000;
    logic        tlb_req;
    logic [29:0] tlb_vpn;
    logic [7:0]  tlb_asid;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_xre = '0;
    logic        rsp_vld;
    logic [43:0] rsp_pa;
    logic [2:0]  rsp_fault;
    logic        rsp_uncached;
    logic [63:0] flt_va;
    logic [63:0] flt_form;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    ift_xlate_unit u_ift_xlate_unit (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_va(req_va),
        .req_phys(req_phys), .cur_mode(cur_mode), .sp_ctl(sp_ctl),
        .cur_asid(cur_asid), .pt_base(pt_base), .tlb_req(tlb_req),
        .tlb_vpn(tlb_vpn), .tlb_asid(tlb_asid), .tlb_hit(tlb_hit),
        .tlb_ppn(tlb_ppn), .tlb_xre(tlb_xre), .rsp_vld(rsp_vld),
        .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_uncached(rsp_uncached),
        .flt_va(flt_va), .flt_form(flt_form)
    );

    typedef struct packed {
        logic [43:0] pa;
        logic [2:0]  f;
        logic        unc;
        logic        rec;
    } exp_t;

    function automatic bit in_spage(logic [63:0] va, logic [1:0] sp);
        return (sp[1] && va[42:41] == 2'd2) || (va[47:41] == 7'h7E);
    endfunction

    function automatic exp_t ref_xlate(logic [63:0] va, logic phys, logic [1:0] mode,
                                       logic [1:0] sp, logic hit, logic [31:0] ppn,
                                       logic [3:0] xre);
        exp_t r;
        logic [63:0] a;
        r = '0;
        a = '0;
        if (va[0]) begin
            a = va & 64'h0000_0FFF_FFFF_FFFC;
        end else if (phys) begin
            a = va;
        end else if (in_spage(va, sp)) begin
            if (mode != 2'd0) begin
                r.f = 3'd1; r.rec = 1'b1;
            end else begin
                a = va & 64'h0000_0FFF_FFFF_FFFF;
                if (a[40]) a = a | 64'h0000_0F00_0000_0000;
                else       a = a & 64'h0000_00FF_FFFF_FFFF;
            end
        end else if (!hit) begin
            r.f = 3'd2; r.rec = 1'b1;
        end else begin
            a = (64'(ppn) << 13) + 64'(va[12:0] & 13'h1FFC);
            if (!xre[mode]) begin
                r.f = 3'd1; r.rec = 1'b1;
            end
        end
        if (r.f == 3'd0 && (a >> 44) != 0) r.f = 3'd3;
        if (r.f == 3'd0 && a[39]) begin
            r.unc = 1'b1;
            a[42:35] = 8'h00;
        end
        r.pa = (r.f == 3'd0) ? a[43:0] : 44'h0;
        return r;
    endfunction

    logic        e_vld = 1'b0;
    exp_t        e_res = '0;
    logic [63:0] e_fva = '0;
    logic [63:0] e_fform = '0;
    string       e_tag = "R1";

    always @(posedge clk) begin
        exp_t t;
        if (rst) begin
            e_vld   <= 1'b0;
            e_res   <= '0;
            e_fva   <= '0;
            e_fform <= '0;
        end else begin
            e_vld <= req_vld;
            if (req_vld) begin
                t = ref_xlate(req_va, req_phys, cur_mode, sp_ctl, tlb_hit, tlb_ppn, tlb_xre);
                e_res <= t;
                e_tag <= cur_tag;
                if (t.rec) begin
                    e_fva   <= req_va;
                    e_fform <= pt_base | (64'(req_va[42:13]) << 3);
                end
            end
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R2", "rsp_vld", 64'(rsp_vld), 64'(e_vld));
        if (e_vld) begin
            chk(e_tag, "rsp_fault", 64'(rsp_fault), 64'(e_res.f));
            chk(e_tag, "rsp_pa", 64'(rsp_pa), 64'(e_res.pa));
            chk(e_tag, "rsp_uncached", 64'(rsp_uncached), 64'(e_res.unc));
        end
        chk("R10", "flt_va", flt_va, e_fva);
        chk("R10", "flt_form", flt_form, e_fform);
    endtask

    task automatic drive(string tag, logic [63:0] va, logic phys, logic [1:0] mode,
                         logic [1:0] sp, logic hit, logic [31:0] ppn, logic [3:0] xre);
        bit mapped;
        cur_tag  = tag;
        req_vld  = 1'b1;
        req_va   = va;
        req_phys = phys;
        cur_mode = mode;
        sp_ctl   = sp;
        tlb_hit  = hit;
        tlb_ppn  = ppn;
        tlb_xre  = xre;
        cur_asid = cur_asid + 8'd3;
        #1;
        mapped = !va[0] && !phys && !in_spage(va, sp);
        chk(va[0] ? "R3" : "R5", "tlb_req", 64'(tlb_req), 64'(mapped));
        if (mapped) begin
            chk("R5", "tlb_vpn", 64'(tlb_vpn), 64'(va[42:13]));
            chk("R5", "tlb_asid", 64'(tlb_asid), 64'(cur_asid));
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        req_vld = 1'b0;
        req_va  = {$urandom, $urandom};
        tlb_hit = 1'b1;
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "rsp_vld", 64'(rsp_vld), 64'd0);
        chk("R1", "rsp_pa", 64'(rsp_pa), 64'd0);
        chk("R1", "rsp_fault", 64'(rsp_fault), 64'd0);
        chk("R1", "flt_va", flt_va, 64'd0);
        chk("R1", "flt_form", flt_form, 64'd0);
        rst = 1'b0;
        // R3 privileged PC, high bits and bit 39 present
        drive("R3", 64'hFFFF_FFFF_FFFF_F003, 1'b0, 2'd3, 2'd0, 1'b0, 32'd0, 4'h0);
        drive("R3", 64'h0000_0000_1234_5679, 1'b1, 2'd1, 2'd2, 1'b0, 32'd0, 4'h0);
        // R4 physical pass-through
        drive("R4", 64'h0000_0012_3456_7890, 1'b1, 2'd3, 2'd0, 1'b0, 32'd0, 4'h0);
        // R11 physical beyond implemented width
        drive("R11", 64'h0001_0000_0000_0000, 1'b1, 2'd0, 2'd0, 1'b0, 32'd0, 4'h0);
        // R12 uncacheable strip
        drive("R12", 64'h0000_0080_0000_1000, 1'b1, 2'd0, 2'd0, 1'b0, 32'd0, 4'h0);
        // R5/R7 narrow superpage
        drive("R7", 64'h0000_0400_0000_2000, 1'b0, 2'd0, 2'd2, 1'b0, 32'd0, 4'h0);
        drive("R7", 64'h0000_0500_0000_3000, 1'b0, 2'd0, 2'd2, 1'b0, 32'd0, 4'h0);
        drive("R12", 64'h0000_0580_0000_4000, 1'b0, 2'd0, 2'd2, 1'b0, 32'd0, 4'h0);
        // R5 wide superpage with control off
        drive("R5", 64'h0000_FC00_0000_0100, 1'b0, 2'd0, 2'd0, 1'b0, 32'd0, 4'h0);
        drive("R12", 64'h0000_FD80_0000_0200, 1'b0, 2'd0, 2'd0, 1'b0, 32'd0, 4'h0);
        // R5 narrow pattern without control bit goes to lookup
        drive("R5", 64'h0000_0400_0000_2468, 1'b0, 2'd0, 2'd0, 1'b1, 32'd5, 4'hF);
        // R6 non-kernel superpage
        drive("R6", 64'h0000_0400_0000_6000, 1'b0, 2'd2, 2'd2, 1'b1, 32'd0, 4'hF);
        idle();
        idle();
        // R8 miss
        drive("R8", 64'h0000_0000_0ABC_E000, 1'b0, 2'd3, 2'd0, 1'b0, 32'd7, 4'hF);
        // R9 execute checks and offset alignment
        drive("R9", 64'h0000_0000_0000_3FFE, 1'b0, 2'd0, 2'd0, 1'b1, 32'h123, 4'b1110);
        drive("R9", 64'h0000_0000_0000_3FFE, 1'b0, 2'd1, 2'd0, 1'b1, 32'h123, 4'b0010);
        drive("R9", 64'h0000_0000_0000_1FFE, 1'b0, 2'd3, 2'd0, 1'b1, 32'h4_0000, 4'b1000);
        // R11 frame beyond width, fault record untouched
        drive("R11", 64'h0000_0000_0000_2000, 1'b0, 2'd0, 2'd0, 1'b1, 32'h8000_0000, 4'hF);
        idle();
        // randomized mix
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] va;
            logic [1:0] sp;
            int kind;
            kind = $urandom_range(0, 6);
            va = {$urandom, $urandom};
            sp = 2'($urandom);
            case (kind)
                0: va[0] = 1'b1;
                1: va[0] = 1'b0;
                2: begin va[0] = 1'b0; va[42:41] = 2'b10; sp[1] = 1'b1; end
                3: begin va[0] = 1'b0; va[47:41] = 7'h7E; end
                default: begin va[0] = 1'b0; va[47:41] = 7'h00; end
            endcase
            if ($urandom_range(0, 9) == 0) idle();
            else drive(kind == 0 ? "R3" : (kind == 1 ? "R4" : (kind < 4 ? "R7" : "R9")),
                       va, kind == 1, 2'($urandom), sp, $urandom_range(0, 3) != 0,
                       32'($urandom) >> $urandom_range(0, 4), 4'($urandom));
        end
        idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule